// File: doc/BRIEF.md
# TLP Header Trace Filter

This block sits beside a PCIe core's header observation point and decides, one header at a time, whether the header should be handed to a trace recorder. Every observed header is presented as a one-cycle valid strobe with its requester ID, the index of the root port it arrived on, its class, its direction and a completion subclass flag. The block answers with a registered capture strobe.

Selection has three parts:
- **Source.** A mode bit picks either a bitmask of root ports or one exact requester ID.
- **Class.** A one-hot class mask picks which header classes are kept.
- **Direction.** A direction code picks the traffic direction. Its meaning depends on whether the recorder writes short or long records.

All settings are sampled on a trace-start pulse and held until a trace-stop pulse. An illegal setting raises an error flag and suppresses every capture for that trace.

Top module: `tlp_trace_filter`

## Requirements
- R1: After reset `capture_o` and `cfg_err_o` are 0, the block is idle, and no header is captured until a trace is started.
- R2: Settings are sampled on the clock edge where `start_i` is high while idle and `stop_i` is low. Later changes on the setting inputs have no effect. A `start_i` pulse during an active trace is ignored. `stop_i` returns the block to idle, where nothing is captured.
- R3: With filter bit 19 = 1 (port mode), a header matches when filter bit `hdr_port_i` (within bits 15:0) is 1. Several ports may be enabled together.
- R4: With filter bit 19 = 0 (requester mode), a header matches only when `hdr_rid_i` equals filter bits 15:0 exactly.
- R5: Type mask bit 0 enables posted headers (`hdr_cls_i` = 0). Bit 1 enables non-posted headers (`hdr_cls_i` = 1). Bit 2 enables completions (`hdr_cls_i` = 2). Class code 3 is never captured.
- R6: Short format (`cfg_long_i` = 0), where `hdr_out_i` = 1 means outbound:
  - code 0 keeps inbound headers only;
  - code 1 keeps outbound headers only;
  - code 2 keeps all outbound headers plus inbound headers, except that inbound completions must have `hdr_cpl_b_i` = 1;
  - code 3 keeps all outbound headers plus inbound completions with `hdr_cpl_b_i` = 0.
- R7: Long format (`cfg_long_i` = 1):
  - code 1 keeps outbound headers;
  - code 2 keeps inbound headers, with inbound completions restricted to `hdr_cpl_b_i` = 1;
  - code 3 keeps inbound completions with `hdr_cpl_b_i` = 0 only;
  - code 0 is reserved.
- R8: When `cfg_dir_vld_i` = 0 the direction defaults to inbound. In short format this behaves as code 0; in long format it behaves as code 2.
- R9: `cfg_err_o` is 1 from the cycle after a start until stop, and no header is captured, when any of these holds:
  - filter bits 18:16 are nonzero;
  - any type mask bit above bit 2 is set;
  - the direction code is 4 or higher;
  - a long-format code 0 was supplied;
  - the direction enables outbound traffic and more than one of type bits 2:0 is set.
- R10: For a header that matches, `capture_o` is high for exactly the one cycle after the `hdr_vld_i` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Trace-start pulse; samples the settings |
| stop_i | input | 1 | Trace-stop pulse |
| cfg_filter_i | input | 20 | Bit 19 mode, bits 18:16 reserved, bits 15:0 port mask or requester ID |
| cfg_type_i | input | 8 | One-hot class mask |
| cfg_dir_i | input | 4 | Direction code |
| cfg_dir_vld_i | input | 1 | Direction code supplied; 0 selects the inbound default |
| cfg_long_i | input | 1 | 1 selects long records, 0 short records |
| hdr_vld_i | input | 1 | Header valid strobe |
| hdr_rid_i | input | 16 | Header requester ID |
| hdr_port_i | input | 4 | Arrival root-port index |
| hdr_cls_i | input | 2 | 0 posted, 1 non-posted, 2 completion |
| hdr_out_i | input | 1 | 1 outbound, 0 inbound |
| hdr_cpl_b_i | input | 1 | Completion subclass: 1 subclass B, 0 subclass A |
| capture_o | output | 1 | Registered capture strobe |
| cfg_err_o | output | 1 | Illegal setting for the current trace |

## Verification
The hardest situation to reach is one where the held settings and the live setting inputs disagree. Only then does a failure to hold the sampled settings become visible. The stimulus starts a trace in requester mode and then drives a different requester ID onto the filter input. It then issues a second start pulse while the trace is still active, and sends headers matching the old and the new ID to show that only the sampled one is captured. Error cases are reached by starting traces with each illegal combination; the outbound multi-type check is reached through short-format codes that enable outbound traffic.

// File: rtl/tlp_trace_pkg.sv
package tlp_trace_pkg;
  typedef enum logic [1:0] {
    CLS_P   = 2'd0,
    CLS_NP  = 2'd1,
    CLS_CPL = 2'd2,
    CLS_RSV = 2'd3
  } hdr_cls_e;

  localparam int NUM_CLS = 3;
  localparam int CODE_W  = 2;

  localparam logic [CODE_W-1:0] DIR_C0 = 2'd0;
  localparam logic [CODE_W-1:0] DIR_C1 = 2'd1;
  localparam logic [CODE_W-1:0] DIR_C2 = 2'd2;
  localparam logic [CODE_W-1:0] DIR_C3 = 2'd3;
endpackage

// File: rtl/tft_cfg_latch.sv
module tft_cfg_latch
  import tlp_trace_pkg::*;
#(
  parameter int RID_W  = 16,
  parameter int TYPE_W = 8,
  parameter int DIR_W  = 4,
  localparam int FLT_W = RID_W + 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic                 stop_i,
  input  logic [FLT_W-1:0]     filter_i,
  input  logic [TYPE_W-1:0]    type_i,
  input  logic [DIR_W-1:0]     dir_i,
  input  logic                 dir_vld_i,
  input  logic                 long_i,
  output logic                 active_o,
  output logic                 err_o,
  output logic                 long_o,
  output logic [FLT_W-1:0]     filter_o,
  output logic [NUM_CLS-1:0]   type_o,
  output logic [CODE_W-1:0]    dir_o
);
  logic [DIR_W-1:0] eff_dir;
  logic             rsv_flt, rsv_type, bad_code, out_en, multi_type, err_d, load;

  always_comb begin
    eff_dir    = dir_vld_i ? dir_i : (long_i ? DIR_W'(2) : DIR_W'(0));
    rsv_flt    = |filter_i[FLT_W-2:RID_W];
    rsv_type   = |type_i[TYPE_W-1:NUM_CLS];
    bad_code   = (eff_dir > DIR_W'(3)) || (long_i && eff_dir == '0);
    out_en     = long_i ? (eff_dir == DIR_W'(1)) : (eff_dir != '0);
    multi_type = $countones(type_i[NUM_CLS-1:0]) > 1;
    err_d      = rsv_flt | rsv_type | bad_code | (out_en & multi_type);
    load       = start_i & ~stop_i & ~active_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
      err_o    <= 1'b0;
      long_o   <= 1'b0;
      filter_o <= '0;
      type_o   <= '0;
      dir_o    <= '0;
    end else if (stop_i) begin
      active_o <= 1'b0;
      err_o    <= 1'b0;
    end else if (load) begin
      active_o <= 1'b1;
      err_o    <= err_d;
      long_o   <= long_i;
      filter_o <= filter_i;
      type_o   <= type_i[NUM_CLS-1:0];
      dir_o    <= eff_dir[CODE_W-1:0];
    end
  end

  // R2: sampled settings hold while tracing
  p_cfg_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o && !stop_i |=> $stable(filter_o) && $stable(type_o) && $stable(dir_o) && $stable(long_o));

  // R9: error flag only present during an active trace
  p_err_active_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> active_o);
endmodule

// File: rtl/tft_src_match.sv
module tft_src_match #(
  parameter int RID_W  = 16,
  parameter int PORT_N = 16,
  localparam int FLT_W  = RID_W + 4,
  localparam int PORT_W = $clog2(PORT_N)
) (
  input  logic [FLT_W-1:0]  filter_i,
  input  logic [RID_W-1:0]  rid_i,
  input  logic [PORT_W-1:0] port_i,
  output logic              hit_o
);
  localparam int MODE_BIT = FLT_W - 1;

  logic [RID_W-1:0] value;
  logic             port_hit, rid_hit;

  always_comb begin
    value    = filter_i[RID_W-1:0];
    port_hit = value[port_i];
    rid_hit  = (rid_i == value);
    hit_o    = filter_i[MODE_BIT] ? port_hit : rid_hit;
  end

  initial begin
    a_port_fits_r3: assert (PORT_N <= RID_W);
  end
endmodule

// File: rtl/tft_dir_match.sv
module tft_dir_match
  import tlp_trace_pkg::*;
(
  input  logic [NUM_CLS-1:0] type_i,
  input  logic [CODE_W-1:0]  dir_i,
  input  logic               long_i,
  input  logic [1:0]         cls_i,
  input  logic               out_i,
  input  logic               cpl_b_i,
  output logic               hit_o
);
  logic cls_ok, in_all, in_b, in_a, dir_ok;

  always_comb begin
    unique case (hdr_cls_e'(cls_i))
      CLS_P:   cls_ok = type_i[0];
      CLS_NP:  cls_ok = type_i[1];
      CLS_CPL: cls_ok = type_i[2];
      default: cls_ok = 1'b0;
    endcase

    in_all = ~out_i;
    // inbound with completions narrowed to subclass B
    in_b   = ~out_i & ((cls_i != CLS_CPL) | cpl_b_i);
    // inbound subclass-A completions only
    in_a   = ~out_i & (cls_i == CLS_CPL) & ~cpl_b_i;

    if (!long_i) begin
      unique case (dir_i)
        DIR_C0:  dir_ok = in_all;
        DIR_C1:  dir_ok = out_i;
        DIR_C2:  dir_ok = out_i | in_b;
        default: dir_ok = out_i | in_a;
      endcase
    end else begin
      unique case (dir_i)
        DIR_C0:  dir_ok = 1'b0;
        DIR_C1:  dir_ok = out_i;
        DIR_C2:  dir_ok = in_b;
        default: dir_ok = in_a;
      endcase
    end

    hit_o = cls_ok & dir_ok;
  end
endmodule

// File: rtl/tlp_trace_filter.sv
module tlp_trace_filter
  import tlp_trace_pkg::*;
#(
  parameter int RID_W  = 16,
  parameter int PORT_N = 16,
  parameter int TYPE_W = 8,
  parameter int DIR_W  = 4,
  localparam int FLT_W  = RID_W + 4,
  localparam int PORT_W = $clog2(PORT_N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [FLT_W-1:0]  cfg_filter_i,
  input  logic [TYPE_W-1:0] cfg_type_i,
  input  logic [DIR_W-1:0]  cfg_dir_i,
  input  logic              cfg_dir_vld_i,
  input  logic              cfg_long_i,
  input  logic              hdr_vld_i,
  input  logic [RID_W-1:0]  hdr_rid_i,
  input  logic [PORT_W-1:0] hdr_port_i,
  input  logic [1:0]        hdr_cls_i,
  input  logic              hdr_out_i,
  input  logic              hdr_cpl_b_i,
  output logic              capture_o,
  output logic              cfg_err_o
);
  logic               active, err, long_q;
  logic [FLT_W-1:0]   filter_q;
  logic [NUM_CLS-1:0] type_q;
  logic [CODE_W-1:0]  dir_q;
  logic               src_hit, dir_hit, match;

  tft_cfg_latch #(
    .RID_W (RID_W),
    .TYPE_W(TYPE_W),
    .DIR_W (DIR_W)
  ) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .stop_i   (stop_i),
    .filter_i (cfg_filter_i),
    .type_i   (cfg_type_i),
    .dir_i    (cfg_dir_i),
    .dir_vld_i(cfg_dir_vld_i),
    .long_i   (cfg_long_i),
    .active_o (active),
    .err_o    (err),
    .long_o   (long_q),
    .filter_o (filter_q),
    .type_o   (type_q),
    .dir_o    (dir_q)
  );

  tft_src_match #(
    .RID_W (RID_W),
    .PORT_N(PORT_N)
  ) u_src (
    .filter_i(filter_q),
    .rid_i   (hdr_rid_i),
    .port_i  (hdr_port_i),
    .hit_o   (src_hit)
  );

  tft_dir_match u_dir (
    .type_i (type_q),
    .dir_i  (dir_q),
    .long_i (long_q),
    .cls_i  (hdr_cls_i),
    .out_i  (hdr_out_i),
    .cpl_b_i(hdr_cpl_b_i),
    .hit_o  (dir_hit)
  );

  assign match     = hdr_vld_i & active & ~err & src_hit & dir_hit;
  assign cfg_err_o = err;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) capture_o <= 1'b0;
    else         capture_o <= match;
  end

  // R10: a capture is always caused by a header in the previous cycle
  p_capture_follows_hdr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_o |-> $past(hdr_vld_i));

  // R9: an erroneous setting blocks the next capture
  p_err_blocks_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |=> !capture_o);

  // R2: idle never captures
  p_idle_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active |=> !capture_o);
endmodule

// File: tb/tlp_trace_filter_test.sv
`timescale 1ns/1ps
module tlp_trace_filter_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0, stop_i = 1'b0;
  logic [19:0] cfg_filter_i = '0;
  logic [7:0]  cfg_type_i = '0;
  logic [3:0]  cfg_dir_i = '0;
  logic        cfg_dir_vld_i = 1'b0, cfg_long_i = 1'b0;
  logic        hdr_vld_i = 1'b0;
  logic [15:0] hdr_rid_i = '0;
  logic [3:0]  hdr_port_i = '0;
  logic [1:0]  hdr_cls_i = '0;
  logic        hdr_out_i = 1'b0, hdr_cpl_b_i = 1'b0;
  logic        capture_o, cfg_err_o;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  tlp_trace_filter uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .stop_i(stop_i),
    .cfg_filter_i(cfg_filter_i), .cfg_type_i(cfg_type_i), .cfg_dir_i(cfg_dir_i),
    .cfg_dir_vld_i(cfg_dir_vld_i), .cfg_long_i(cfg_long_i),
    .hdr_vld_i(hdr_vld_i), .hdr_rid_i(hdr_rid_i), .hdr_port_i(hdr_port_i),
    .hdr_cls_i(hdr_cls_i), .hdr_out_i(hdr_out_i), .hdr_cpl_b_i(hdr_cpl_b_i),
    .capture_o(capture_o), .cfg_err_o(cfg_err_o)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0b exp=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic start_trace(input logic [19:0] f, input logic [7:0] ty,
                             input logic [3:0] d, input logic dv, input logic lg);
    cfg_filter_i = f; cfg_type_i = ty; cfg_dir_i = d; cfg_dir_vld_i = dv; cfg_long_i = lg;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic stop_trace();
    stop_i = 1'b1;
    @(negedge clk);
    stop_i = 1'b0;
  endtask

  // drive one header, check capture in the following cycle and that it drops after
  task automatic send(input string req, input logic [15:0] rid, input logic [3:0] port,
                      input logic [1:0] cls, input logic out, input logic b, input logic exp);
    hdr_rid_i = rid; hdr_port_i = port; hdr_cls_i = cls; hdr_out_i = out; hdr_cpl_b_i = b;
    hdr_vld_i = 1'b1;
    @(negedge clk);
    hdr_vld_i = 1'b0;
    chk(req, capture_o, exp);
    @(negedge clk);
    chk("R10 single pulse", capture_o, 1'b0);
  endtask

  task automatic t_reset();
    chk("R1 capture after reset", capture_o, 1'b0);
    chk("R1 err after reset", cfg_err_o, 1'b0);
    send("R1 idle header", 16'h0000, 4'd0, 2'd0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_port_mode();
    start_trace(20'h80022, 8'h07, 4'd0, 1'b1, 1'b0);
    chk("R3 no err", cfg_err_o, 1'b0);
    send("R3 port 1 enabled", 16'h1234, 4'd1, 2'd0, 1'b0, 1'b0, 1'b1);
    send("R3 port 2 disabled", 16'h1234, 4'd2, 2'd0, 1'b0, 1'b0, 1'b0);
    send("R3 port 5 enabled", 16'h0000, 4'd5, 2'd2, 1'b0, 1'b1, 1'b1);
    stop_trace();
  endtask

  task automatic t_rid_mode();
    start_trace(20'h00101, 8'h07, 4'd0, 1'b1, 1'b0);
    send("R4 rid equal", 16'h0101, 4'd3, 2'd1, 1'b0, 1'b0, 1'b1);
    send("R4 rid differs", 16'h0102, 4'd3, 2'd1, 1'b0, 1'b0, 1'b0);
    send("R4 port bit ignored", 16'h0001, 4'd0, 2'd1, 1'b0, 1'b0, 1'b0);
    stop_trace();
  endtask

  task automatic t_type();
    start_trace(20'h8FFFF, 8'h02, 4'd0, 1'b1, 1'b0);
    send("R5 posted masked", 16'h0, 4'd0, 2'd0, 1'b0, 1'b0, 1'b0);
    send("R5 nonposted kept", 16'h0, 4'd0, 2'd1, 1'b0, 1'b0, 1'b1);
    send("R5 completion masked", 16'h0, 4'd0, 2'd2, 1'b0, 1'b1, 1'b0);
    send("R5 class 3 never", 16'h0, 4'd0, 2'd3, 1'b0, 1'b0, 1'b0);
    stop_trace();
  endtask

  task automatic t_short_dir();
    start_trace(20'h8FFFF, 8'h01, 4'd1, 1'b1, 1'b0);
    send("R6 c1 outbound", 16'h0, 4'd0, 2'd0, 1'b1, 1'b0, 1'b1);
    send("R6 c1 inbound", 16'h0, 4'd0, 2'd0, 1'b0, 1'b0, 1'b0);
    stop_trace();
    start_trace(20'h8FFFF, 8'h04, 4'd2, 1'b1, 1'b0);
    send("R6 c2 out cpl", 16'h0, 4'd0, 2'd2, 1'b1, 1'b0, 1'b1);
    send("R6 c2 in cpl B", 16'h0, 4'd0, 2'd2, 1'b0, 1'b1, 1'b1);
    send("R6 c2 in cpl A", 16'h0, 4'd0, 2'd2, 1'b0, 1'b0, 1'b0);
    stop_trace();
    start_trace(20'h8FFFF, 8'h04, 4'd3, 1'b1, 1'b0);
    send("R6 c3 out cpl", 16'h0, 4'd0, 2'd2, 1'b1, 1'b1, 1'b1);
    send("R6 c3 in cpl A", 16'h0, 4'd0, 2'd2, 1'b0, 1'b0, 1'b1);
    send("R6 c3 in cpl B", 16'h0, 4'd0, 2'd2, 1'b0, 1'b1, 1'b0);
    stop_trace();
    start_trace(20'h8FFFF, 8'h01, 4'd3, 1'b1, 1'b0);
    send("R6 c3 in posted", 16'h0, 4'd0, 2'd0, 1'b0, 1'b0, 1'b0);
    stop_trace();
  endtask

  task automatic t_long_dir();
    start_trace(20'h8FFFF, 8'h02, 4'd1, 1'b1, 1'b1);
    chk("R7 c1 no err", cfg_err_o, 1'b0);
    send("R7 c1 outbound", 16'h0, 4'd0, 2'd1, 1'b1, 1'b0, 1'b1);
    send("R7 c1 inbound", 16'h0, 4'd0, 2'd1, 1'b0, 1'b0, 1'b0);
    stop_trace();
    start_trace(20'h8FFFF, 8'h07, 4'd2, 1'b1, 1'b1);
    chk("R7 c2 multi type ok", cfg_err_o, 1'b0);
    send("R7 c2 in posted", 16'h0, 4'd0, 2'd0, 1'b0, 1'b0, 1'b1);
    send("R7 c2 in cpl B", 16'h0, 4'd0, 2'd2, 1'b0, 1'b1, 1'b1);
    send("R7 c2 in cpl A", 16'h0, 4'd0, 2'd2, 1'b0, 1'b0, 1'b0);
    send("R7 c2 outbound", 16'h0, 4'd0, 2'd0, 1'b1, 1'b0, 1'b0);
    stop_trace();
    start_trace(20'h8FFFF, 8'h04, 4'd3, 1'b1, 1'b1);
    send("R7 c3 in cpl A", 16'h0, 4'd0, 2'd2, 1'b0, 1'b0, 1'b1);
    send("R7 c3 in cpl B", 16'h0, 4'd0, 2'd2, 1'b0, 1'b1, 1'b0);
    send("R7 c3 out cpl", 16'h0, 4'd0, 2'd2, 1'b1, 1'b0, 1'b0);
    stop_trace();
  endtask

  task automatic t_default_dir();
    start_trace(20'h8FFFF, 8'h07, 4'd1, 1'b0, 1'b0);
    chk("R8 short default no err", cfg_err_o, 1'b0);
    send("R8 short default inbound", 16'h0, 4'd0, 2'd0, 1'b0, 1'b0, 1'b1);
    send("R8 short default outbound", 16'h0, 4'd0, 2'd0, 1'b1, 1'b0, 1'b0);
    stop_trace();
    start_trace(20'h8FFFF, 8'h07, 4'd0, 1'b0, 1'b1);
    chk("R8 long default no err", cfg_err_o, 1'b0);
    send("R8 long default cpl B", 16'h0, 4'd0, 2'd2, 1'b0, 1'b1, 1'b1);
    send("R8 long default cpl A", 16'h0, 4'd0, 2'd2, 1'b0, 1'b0, 1'b0);
    stop_trace();
  endtask

  task automatic t_errors();
    start_trace(20'h90001, 8'h07, 4'd0, 1'b1, 1'b0);
    chk("R9 reserved filter bit", cfg_err_o, 1'b1);
    send("R9 blocked capture", 16'h0, 4'd0, 2'd0, 1'b0, 1'b0, 1'b0);
    stop_trace();
    chk("R9 err cleared by stop", cfg_err_o, 1'b0);
    start_trace(20'h8FFFF, 8'h07, 4'd5, 1'b1, 1'b0);
    chk("R9 code 5", cfg_err_o, 1'b1);
    stop_trace();
    start_trace(20'h8FFFF, 8'h07, 4'd0, 1'b1, 1'b1);
    chk("R9 long code 0 supplied", cfg_err_o, 1'b1);
    stop_trace();
    start_trace(20'h8FFFF, 8'h03, 4'd1, 1'b1, 1'b0);
    chk("R9 outbound multi type", cfg_err_o, 1'b1);
    send("R9 outbound blocked", 16'h0, 4'd0, 2'd0, 1'b1, 1'b0, 1'b0);
    stop_trace();
    start_trace(20'h8FFFF, 8'h09, 4'd0, 1'b1, 1'b0);
    chk("R9 reserved type bit", cfg_err_o, 1'b1);
    stop_trace();
    start_trace(20'h8FFFF, 8'h07, 4'd0, 1'b1, 1'b0);
    chk("R9 inbound multi type ok", cfg_err_o, 1'b0);
    stop_trace();
  endtask

  task automatic t_hold();
    start_trace(20'h00101, 8'h07, 4'd0, 1'b1, 1'b0);
    cfg_filter_i = 20'h00202;
    cfg_long_i = 1'b1;
    send("R2 held rid kept", 16'h0101, 4'd0, 2'd0, 1'b0, 1'b0, 1'b1);
    send("R2 live rid ignored", 16'h0202, 4'd0, 2'd0, 1'b0, 1'b0, 1'b0);
    start_trace(20'h00202, 8'h07, 4'd0, 1'b1, 1'b0);
    send("R2 restart ignored", 16'h0202, 4'd0, 2'd0, 1'b0, 1'b0, 1'b0);
    stop_trace();
    send("R2 stopped", 16'h0101, 4'd0, 2'd0, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_port_mode();
    t_rid_mode();
    t_type();
    t_short_dir();
    t_long_dir();
    t_default_dir();
    t_errors();
    t_hold();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule